// File: doc/BRIEF.md
# Pointer-Relative Address Generator

This block turns a compact 9-bit address expression into an effective memory address, using one of two pointer registers as the base. The expression chooses the pointer, says whether the pointer is written back, chooses between the pre-modified and the untouched pointer as the address, and carries a small signed index. The index is scaled by the access size, so one encoding walks bytes, words, longs or 16-byte quads.

A separate command port sets a pointer, adds to it or subtracts from it. The operand is either a full-width register value or a zero-extended 9-bit literal. A read port returns either pointer together with its top bit as a carry flag. The effective address is combinational from the current pointers and the expression. Pointer updates take effect on the next rising clock edge.

Top module: `ptr_addr_gen`

## Requirements
- R1: The expression `expr` is decoded as follows. Bit 8 selects the pointer (0 = pointer A, 1 = pointer B). Bit 7 is the write-back flag. Bit 6 is the post-modify flag. Bits 5:0 are a two's-complement index, so 000001 is +1 and 111111 is -1.
- R2: The index is scaled by the access size. `size` 0 (byte) scales by 1, 1 (word) by 2, 2 (long) by 4 and 3 (quad) by 16.
- R3: An access with the write-back flag at 0 leaves both pointers unchanged.
- R4: An access with the write-back flag at 1 makes the selected pointer equal to pointer + scaled index after the next clock edge. The other pointer is unchanged.
- R5: With the post-modify flag at 0, `eff_addr` equals the selected pointer + scaled index. With it at 1, `eff_addr` equals the selected pointer as it stands. The address is valid in the same cycle as `mem_go`.
- R6: A command with `cmd_op` 0 loads the pointer chosen by `cmd_sel` (0 = A, 1 = B). The value loaded is `cmd_reg` when `cmd_imm` is 0, and the zero-extended 9-bit `cmd_lit` (0..511) when `cmd_imm` is 1.
- R7: `cmd_op` 1 adds the operand to the chosen pointer and `cmd_op` 2 subtracts it. `cmd_op` 3 leaves the pointer unchanged.
- R8: `rd_ptr` returns pointer A when `rd_sel` is 0 and pointer B when it is 1. `rd_carry` returns bit 16 of the value read.
- R9: When a command and a write-back access hit the same pointer in one cycle, the command wins. When they hit different pointers, both take effect.
- R10: After reset both pointers are zero.
- R11: All pointer and address arithmetic wraps modulo 2^17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_go | input | 1 | Apply the address expression this cycle |
| expr | input | 9 | Address expression |
| size | input | 2 | Access size: byte, word, long, quad |
| cmd_go | input | 1 | Apply a pointer command this cycle |
| cmd_op | input | 2 | 0 set, 1 add, 2 subtract, 3 none |
| cmd_sel | input | 1 | Command target: 0 A, 1 B |
| cmd_imm | input | 1 | Use the literal operand instead of the register operand |
| cmd_reg | input | 17 | Register operand |
| cmd_lit | input | 9 | Literal operand, 0..511 |
| rd_sel | input | 1 | Readback select: 0 A, 1 B |
| eff_addr | output | 17 | Effective address |
| ptr_a | output | 17 | Pointer A |
| ptr_b | output | 17 | Pointer B |
| rd_ptr | output | 17 | Selected pointer for readback |
| rd_carry | output | 1 | Bit 16 of the readback value |

## Verification
The bench builds the block with its default widths: 17-bit pointers, a 6-bit index and a 9-bit literal. At these widths every one of the 512 expressions can be swept under all four access sizes. Each combination starts from freshly loaded pointer values, spread so that some lie close to 0 and some close to 2^17; negative indices and quad scaling therefore wrap in both directions. Directed sequences cover the literal-versus-register operand choice, add and subtract wrap, the inert command code, and same-cycle collisions between a command and a write-back.

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int PTR_W = 17,
  parameter int IDX_W = 6,
  parameter int IMM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_go,
  input  logic [IDX_W+2:0] expr,
  input  logic [1:0]       size,
  input  logic             cmd_go,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_sel,
  input  logic             cmd_imm,
  input  logic [PTR_W-1:0] cmd_reg,
  input  logic [IMM_W-1:0] cmd_lit,
  input  logic             rd_sel,
  output logic [PTR_W-1:0] eff_addr,
  output logic [PTR_W-1:0] ptr_a,
  output logic [PTR_W-1:0] ptr_b,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             rd_carry
);

  localparam int EXPR_W = IDX_W + 3;

  logic [1:0][PTR_W-1:0] ptr_q;
  logic                  x_sel, x_upd, x_post;
  logic [IDX_W-1:0]      x_idx;
  logic [PTR_W-1:0]      idx_ext, step, base, moved;
  logic [PTR_W-1:0]      opnd, cmd_base, cmd_res;

  assign x_sel   = expr[EXPR_W-1];
  assign x_upd   = expr[EXPR_W-2];
  assign x_post  = expr[EXPR_W-3];
  assign x_idx   = expr[IDX_W-1:0];
  assign idx_ext = {{(PTR_W-IDX_W){x_idx[IDX_W-1]}}, x_idx};

  always_comb begin
    case (size)
      2'd0:    step = idx_ext;
      2'd1:    step = idx_ext << 1;
      2'd2:    step = idx_ext << 2;
      default: step = idx_ext << 4;
    endcase
  end

  assign base     = ptr_q[x_sel];
  assign moved    = base + step;
  assign eff_addr = x_post ? base : moved;

  assign opnd     = cmd_imm ? {{(PTR_W-IMM_W){1'b0}}, cmd_lit} : cmd_reg;
  assign cmd_base = ptr_q[cmd_sel];

  always_comb begin
    case (cmd_op)
      2'd0:    cmd_res = opnd;
      2'd1:    cmd_res = cmd_base + opnd;
      2'd2:    cmd_res = cmd_base - opnd;
      default: cmd_res = cmd_base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (cmd_go && cmd_sel == 1'(k))
          ptr_q[k] <= cmd_res;
        else if (mem_go && x_upd && x_sel == 1'(k))
          ptr_q[k] <= moved;
      end
    end
  end

  assign ptr_a    = ptr_q[0];
  assign ptr_b    = ptr_q[1];
  assign rd_ptr   = rd_sel ? ptr_b : ptr_a;
  assign rd_carry = rd_ptr[PTR_W-1];

  a_r3_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_go && !x_upd && !cmd_go) |=> ($stable(ptr_a) && $stable(ptr_b)));

  a_r4_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_go && !x_sel && !cmd_go) |=> $stable(ptr_b));

  a_r5_post_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_go && x_post) |-> (eff_addr == (x_sel ? ptr_b : ptr_a)));

  a_r6_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd_op == 2'd0 && !cmd_sel) |=> (ptr_a == $past(opnd)));

  a_r7_op3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd_op == 2'd3 && !mem_go) |=> ($stable(ptr_a) && $stable(ptr_b)));

endmodule

// File: tb/ptr_addr_gen_bench.sv
module ptr_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_go = 1'b0;
  logic [8:0]  expr = '0;
  logic [1:0]  size = '0;
  logic        cmd_go = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic        cmd_sel = 1'b0;
  logic        cmd_imm = 1'b0;
  logic [16:0] cmd_reg = '0;
  logic [8:0]  cmd_lit = '0;
  logic        rd_sel = 1'b0;
  logic [16:0] eff_addr, ptr_a, ptr_b, rd_ptr;
  logic        rd_carry;

  int n_chk = 0;
  int n_bad = 0;
  logic [16:0] ea, eb;

  always #2 clk = ~clk;

  ptr_addr_gen u_ptr_addr_gen (
    .clk(clk), .rst_n(rst_n), .mem_go(mem_go), .expr(expr), .size(size),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_imm(cmd_imm),
    .cmd_reg(cmd_reg), .cmd_lit(cmd_lit), .rd_sel(rd_sel),
    .eff_addr(eff_addr), .ptr_a(ptr_a), .ptr_b(ptr_b),
    .rd_ptr(rd_ptr), .rd_carry(rd_carry));

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_ptrs(input string tag);
    chk({tag, " ptr_a"}, ptr_a, ea);
    chk({tag, " ptr_b"}, ptr_b, eb);
  endtask

  function automatic logic [16:0] scaled(input logic [5:0] idx, input logic [1:0] sz);
    logic [16:0] sx;
    sx = {{11{idx[5]}}, idx};
    return sx << ((sz == 2'd3) ? 4 : int'(sz));
  endfunction

  task automatic command(input logic [1:0] op, input logic sel, input logic imm,
                         input logic [16:0] rv, input logic [8:0] lit);
    logic [16:0] o;
    o = imm ? {8'd0, lit} : rv;
    cmd_go = 1'b1; cmd_op = op; cmd_sel = sel; cmd_imm = imm; cmd_reg = rv; cmd_lit = lit;
    @(negedge clk);
    cmd_go = 1'b0;
    if (op != 2'd3) begin
      if (!sel) ea = (op == 2'd0) ? o : (op == 2'd1) ? ea + o : ea - o;
      else      eb = (op == 2'd0) ? o : (op == 2'd1) ? eb + o : eb - o;
    end
  endtask

  task automatic access(input logic [8:0] e, input logic [1:0] sz, input string tag);
    logic [16:0] b, m;
    b = e[8] ? eb : ea;
    m = b + scaled(e[5:0], sz);
    mem_go = 1'b1; expr = e; size = sz;
    #1;
    chk({tag, " R5 R2 R1 R11 eff_addr"}, eff_addr, e[6] ? b : m);
    @(negedge clk);
    mem_go = 1'b0;
    if (e[7]) begin
      if (e[8]) eb = m; else ea = m;
    end
    chk_ptrs({tag, e[7] ? " R4" : " R3"});
  endtask

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    ea = '0; eb = '0;
    cmd_reg = 17'h1ABCD;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_ptrs("R10 reset");

    // R8 readback and carry
    command(2'd0, 1'b0, 1'b0, 17'h1F00F, 9'd0);
    command(2'd0, 1'b1, 1'b0, 17'h0ABCD, 9'd0);
    rd_sel = 1'b0; #1;
    chk("R8 rd_ptr A", rd_ptr, 17'h1F00F);
    chk("R8 carry A", {16'd0, rd_carry}, 17'd1);
    rd_sel = 1'b1; #1;
    chk("R8 rd_ptr B", rd_ptr, 17'h0ABCD);
    chk("R8 carry B", {16'd0, rd_carry}, 17'd0);
    @(negedge clk);

    // R6 literal operand ignores the register value
    command(2'd0, 1'b0, 1'b1, 17'h1FFFF, 9'd511);
    chk_ptrs("R6 set literal");
    command(2'd0, 1'b1, 1'b0, 17'h12345, 9'd7);
    chk_ptrs("R6 set register");

    // R7 add and subtract with wrap, op 3 inert
    command(2'd0, 1'b0, 1'b0, 17'h1FFF0, 9'd0);
    command(2'd1, 1'b0, 1'b1, 17'h0, 9'd32);
    chk_ptrs("R7 R11 add wrap");
    command(2'd2, 1'b0, 1'b1, 17'h0, 9'd100);
    chk_ptrs("R7 R11 sub wrap");
    command(2'd1, 1'b1, 1'b0, 17'h10000, 9'd0);
    chk_ptrs("R7 add register");
    command(2'd2, 1'b1, 1'b0, 17'h00345, 9'd0);
    chk_ptrs("R7 sub register");
    command(2'd3, 1'b0, 1'b0, 17'h1111, 9'd3);
    chk_ptrs("R7 op3 no effect");

    // R9 collisions
    command(2'd0, 1'b0, 1'b0, 17'h00100, 9'd0);
    mem_go = 1'b1; expr = 9'b0_1_0_000001; size = 2'd2;
    cmd_go = 1'b1; cmd_op = 2'd0; cmd_sel = 1'b0; cmd_imm = 1'b1; cmd_lit = 9'd77;
    @(negedge clk);
    mem_go = 1'b0; cmd_go = 1'b0;
    ea = 17'd77;
    chk_ptrs("R9 same pointer command wins");
    mem_go = 1'b1; expr = 9'b1_1_1_111111; size = 2'd3;
    cmd_go = 1'b1; cmd_op = 2'd1; cmd_sel = 1'b0; cmd_imm = 1'b1; cmd_lit = 9'd3;
    @(negedge clk);
    mem_go = 1'b0; cmd_go = 1'b0;
    ea = ea + 17'd3; eb = eb - 17'd16;
    chk_ptrs("R9 different pointers both");

    // R1 R2 R3 R4 R5 R11 sweep of every expression and size
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 512; e++) begin
        command(2'd0, 1'b0, 1'b0, 17'((e * 977 + s * 31013) ^ ((e & 16) != 0 ? 17'h1FFC0 : 17'h0)), 9'd0);
        command(2'd0, 1'b1, 1'b0, 17'((e * 4099 + s * 777) ^ ((e & 32) != 0 ? 17'h0 : 17'h1FFC0)), 9'd0);
        access(9'(e), 2'(s), "sweep");
      end
    end
    finish_up();
  end
endmodule